// File: doc/BRIEF.md
# ATM Cell HEC Generator/Inserter

This block sits in the transmit path of a cell-based physical layer. It takes 53-octet ATM cells one byte per accepted clock. Each cell is marked at its first octet by a start flag and tagged as either an assigned cell or an idle cell. Over header octets 1 to 4 it runs a CRC-8 with generator x^8 + x^2 + x + 1, feeding bits MSB first. It can add the fixed coset pattern 0x55 to the result, modulo 2. The fifth octet is then either replaced with that value or forwarded unchanged.

A three-bit control register sets the behaviour. One bit covers assigned cells, one covers idle cells, and one covers the coset addition. The register is sampled when a cell starts, so each cell is handled as a whole under one setting. Every accepted byte comes out exactly one clock later, and the flags travel with it. The cell length and octet order never change.

The controlling state machine has four states:
- `ST_IDLE` waits outside a cell.
- `ST_HDR` accumulates the header CRC.
- `ST_HEC` is the state in which octet 5 arrives.
- `ST_PAY` carries payload octets 6 to 53.

Transitions are as follows:
- A start byte always enters `ST_HDR`, or directly `ST_HEC` when the header is one octet long.
- `ST_HDR` moves to `ST_HEC` once the fourth header octet is taken.
- `ST_HEC` moves to `ST_PAY` on the fifth octet.
- `ST_PAY` returns to `ST_IDLE` after octet 53.
- Cycles without a byte strobe leave the state as it is.

Top module: `atm_hec_inserter`

## Requirements
- R1: The HEC is a CRC-8 with polynomial 0x07 (x^8+x^2+x+1). The register starts at 0x00 for each cell and takes octets 1 to 4 MSB first.
- R2: When the latched coset bit is 1, the inserted value is the CRC XOR 0x55. When it is 0, the inserted value is the bare CRC, so an all-zero header gives 0x55 or 0x00 respectively.
- R3: For an assigned cell (in_idle=0 on its start byte), octet 5 is replaced by the HEC when control bit 5 is 1. When bit 5 is 0, octet 5 is forwarded exactly as received.
- R4: For an idle cell (in_idle=1 on its start byte), octet 5 is replaced by the HEC when control bit 1 is 1. When bit 1 is 0, the whole idle cell is forwarded unmodified. Control bit 6 selects the coset addition.
- R5: After reset the control register reads as bits 6, 5 and 1 set (0x62). Insertion for both cell kinds and the coset addition are therefore active, and the other control bits have no effect.
- R6: Each accepted byte appears at the output one clock later with out_valid, out_soc and out_idle repeating the inputs. Every octet other than octet 5 is unchanged.
- R7: The control bits are sampled on the start byte of a cell. A write during a cell affects only the following cell.
- R8: A start byte begins a new cell at octet 1 at any point, even inside a cell. Bytes received before any start byte or after octet 53 pass unchanged.
- R9: Cycles with in_valid=0 do not advance the octet position and give out_valid=0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control write data: bit 6 coset, bit 5 assigned-cell insert, bit 1 idle-cell insert |
| in_valid | input | 1 | Input byte strobe |
| in_soc | input | 1 | Input byte is octet 1 of a cell |
| in_idle | input | 1 | Cell is an idle cell (sampled with in_soc) |
| in_data | input | 8 | Input octet |
| out_valid | output | 1 | Output byte strobe |
| out_soc | output | 1 | Output byte is octet 1 |
| out_idle | output | 1 | Idle tag repeated from input |
| out_data | output | 8 | Output octet, octet 5 possibly replaced |

## Verification
Every result of this block appears one clock after the byte that caused it. This holds for octet 5 carrying the HEC, the passed-through octets and the repeated flags alike. The bench drives each byte on a falling edge and records the outputs on the following falling edge, which comes half a period after the register that produces them. Each cell is compared only after two further idle falling edges, so the last octet has been captured. Control writes land on the rising edge together with the byte they accompany, so R7 is checked on the cell that follows that byte.

// File: rtl/atm_hec_pkg.sv
package atm_hec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_HEC  = 2'd2,
        ST_PAY  = 2'd3
    } cell_state_t;

    typedef struct packed {
        logic ins;
        logic coset;
    } cell_mode_t;

endpackage

// File: rtl/hec_crc8_step.sv
module hec_crc8_step #(
    parameter int          W    = 8,
    parameter logic [W-1:0] POLY = 8'h07
) (
    input  logic [W-1:0] crc_in,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] crc_out
);
    always_comb begin
        logic [W-1:0] c;
        c = crc_in;
        for (int i = W - 1; i >= 0; i--) begin
            if (c[W-1] ^ data_in[i]) c = {c[W-2:0], 1'b0} ^ POLY;
            else                     c = {c[W-2:0], 1'b0};
        end
        crc_out = c;
    end
endmodule

// File: rtl/hec_cfg_reg.sv
module hec_cfg_reg #(
    parameter int W         = 8,
    parameter int COSET_BIT = 6,
    parameter int VALID_BIT = 5,
    parameter int IDLE_BIT  = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic         coset_en,
    output logic         valid_en,
    output logic         idle_en
);
    logic cfg_unused;
    assign cfg_unused = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coset_en <= 1'b1;
            valid_en <= 1'b1;
            idle_en  <= 1'b1;
        end else if (we) begin
            coset_en <= wdata[COSET_BIT];
            valid_en <= wdata[VALID_BIT];
            idle_en  <= wdata[IDLE_BIT];
        end
    end
endmodule

// File: rtl/hec_cell_fsm.sv
module hec_cell_fsm
    import atm_hec_pkg::*;
#(
    parameter int           W        = 8,
    parameter int           CELL_LEN = 53,
    parameter int           HDR_LEN  = 4,
    parameter logic [W-1:0] POLY     = 8'h07,
    parameter logic [W-1:0] COSET    = 8'h55
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         in_soc,
    input  logic         in_idle,
    input  logic [W-1:0] in_data,
    input  logic         coset_en,
    input  logic         valid_en,
    input  logic         idle_en,
    output logic         hec_sel,
    output logic [W-1:0] hec_val,
    output cell_mode_t   mode_q
);
    localparam int CNT_W = $clog2(CELL_LEN + 1);

    cell_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [W-1:0]     crc_q, crc_d, crc_seed, crc_next;
    cell_mode_t       mode_d;

    assign crc_seed = in_soc ? '0 : crc_q;

    hec_crc8_step #(.W(W), .POLY(POLY)) u_step (
        .crc_in  (crc_seed),
        .data_in (in_data),
        .crc_out (crc_next)
    );

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        crc_d   = crc_q;
        mode_d  = mode_q;
        if (in_valid) begin
            if (in_soc) begin
                state_d      = (HDR_LEN == 1) ? ST_HEC : ST_HDR;
                cnt_d        = CNT_W'(1);
                crc_d        = crc_next;
                mode_d.ins   = in_idle ? idle_en : valid_en;
                mode_d.coset = coset_en;
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_HDR: begin
                        crc_d = crc_next;
                        cnt_d = cnt_q + CNT_W'(1);
                        if (cnt_q + CNT_W'(1) == CNT_W'(HDR_LEN)) state_d = ST_HEC;
                    end
                    ST_HEC: begin
                        cnt_d   = cnt_q + CNT_W'(1);
                        state_d = ST_PAY;
                    end
                    ST_PAY: begin
                        cnt_d = cnt_q + CNT_W'(1);
                        if (cnt_q + CNT_W'(1) == CNT_W'(CELL_LEN)) state_d = ST_IDLE;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            crc_q   <= '0;
            mode_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            crc_q   <= crc_d;
            mode_q  <= mode_d;
        end
    end

    always_comb begin
        hec_sel = in_valid && !in_soc && (state_q == ST_HEC) && mode_q.ins;
        hec_val = crc_q ^ (mode_q.coset ? COSET : '0);
    end
endmodule

// File: rtl/atm_hec_inserter.sv
module atm_hec_inserter
    import atm_hec_pkg::*;
#(
    parameter int W        = 8,
    parameter int CELL_LEN = 53,
    parameter int HDR_LEN  = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [W-1:0] cfg_wdata,
    input  logic         in_valid,
    input  logic         in_soc,
    input  logic         in_idle,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic         out_soc,
    output logic         out_idle,
    output logic [W-1:0] out_data
);
    logic         coset_en, valid_en, idle_en;
    logic         hec_sel;
    logic [W-1:0] hec_val;
    cell_mode_t   mode_q;

    hec_cfg_reg #(.W(W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .coset_en (coset_en),
        .valid_en (valid_en),
        .idle_en  (idle_en)
    );

    hec_cell_fsm #(.W(W), .CELL_LEN(CELL_LEN), .HDR_LEN(HDR_LEN)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_soc   (in_soc),
        .in_idle  (in_idle),
        .in_data  (in_data),
        .coset_en (coset_en),
        .valid_en (valid_en),
        .idle_en  (idle_en),
        .hec_sel  (hec_sel),
        .hec_val  (hec_val),
        .mode_q   (mode_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_soc   <= 1'b0;
            out_idle  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_soc   <= in_valid && in_soc;
            out_idle  <= in_idle;
            out_data  <= hec_sel ? hec_val : in_data;
        end
    end
endmodule

// File: rtl/hec_checker.sv
module hec_checker
    import atm_hec_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_soc,
    input logic [W-1:0] in_data,
    input logic         out_valid,
    input logic         out_soc,
    input logic [W-1:0] out_data,
    input logic         hec_sel,
    input logic [W-1:0] hec_val,
    input cell_mode_t   mode_q
);
    // R6: one-clock delay on the strobe
    a_r6_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid));

    // R6: start flag follows its byte
    a_r6_soc_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_soc == $past(in_valid && in_soc));

    // R6: unselected octets pass unchanged
    a_r6_pass: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && !$past(hec_sel)) |-> out_data == $past(in_data));

    // R3: selected octet carries the computed value
    a_r3_hec_out: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hec_sel)) |-> out_data == $past(hec_val));

    // R7: cell mode only changes on a start byte
    a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid && in_soc)) |-> $stable(mode_q));

    // R9: no replacement without a byte
    a_r9_no_gap_sel: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !hec_sel);
endmodule

bind atm_hec_inserter hec_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_soc    (in_soc),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_soc   (out_soc),
    .out_data  (out_data),
    .hec_sel   (hec_sel),
    .hec_val   (hec_val),
    .mode_q    (mode_q)
);

// File: tb/sim_atm_hec_inserter.sv
module sim_atm_hec_inserter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       in_valid = 1'b0, in_soc = 1'b0, in_idle = 1'b0;
    logic [7:0] in_data = '0;
    logic       out_valid, out_soc, out_idle;
    logic [7:0] out_data;

    int checks = 0, errors = 0;
    logic [7:0] sent [0:63];
    logic [7:0] obuf [0:63];
    logic       osoc [0:63];
    logic       oidl [0:63];
    int         ocnt = 0;

    always #4 clk = ~clk;

    atm_hec_inserter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .in_valid(in_valid), .in_soc(in_soc), .in_idle(in_idle), .in_data(in_data),
        .out_valid(out_valid), .out_soc(out_soc), .out_idle(out_idle), .out_data(out_data)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid && ocnt < 64) begin
            obuf[ocnt] = out_data;
            osoc[ocnt] = out_soc;
            oidl[ocnt] = out_idle;
            ocnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_model(input logic [31:0] hdr);
        logic [7:0] c = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            logic fb = c[7] ^ hdr[i];
            c = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
        end
        return c;
    endfunction

    task automatic send_cell(input logic [39:0] hdr, input logic idle, input int n,
                             input bit gap, input int wr_at, input logic [7:0] wr_val);
        ocnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cfg_we = 1'b0;
            if (gap && (i % 3 == 1)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            sent[i]  = (i < 5) ? hdr[39 - 8*i -: 8] : 8'(i * 7 + 3);
            in_valid = 1'b1;
            in_soc   = (i == 0);
            in_idle  = idle;
            in_data  = sent[i];
            if (i == wr_at) begin
                cfg_we = 1'b1;
                cfg_wdata = wr_val;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_soc = 1'b0; cfg_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_cell(input logic [7:0] exp5, input int n, input logic idle, input string tag);
        int bad = 0;
        chk(ocnt == n, {tag, " R9 byte count"}, ocnt, n);
        if (n >= 5) chk(obuf[4] == exp5, {tag, " octet5"}, obuf[4], exp5);
        for (int i = 0; i < n && i < ocnt; i++) begin
            if (i != 4 && obuf[i] != sent[i]) bad++;
            if (osoc[i] != (i == 0) || oidl[i] != idle) bad++;
        end
        chk(bad == 0, {tag, " R6 other octets and flags"}, bad, 0);
    endtask

    function automatic logic [7:0] exp_hec(input logic [39:0] hdr, input bit ins, input bit cos);
        if (!ins) return hdr[7:0];
        return crc_model(hdr[39:8]) ^ (cos ? 8'h55 : 8'h00);
    endfunction

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    localparam logic [39:0] HA = 40'hA53C0F81_C7;
    localparam logic [39:0] HB = 40'h12345678_9A;

    task automatic t_reset();
        chk(out_valid == 1'b0 && out_data == 8'h00, "R6 reset outputs", {out_valid, out_data}, 0);
    endtask

    task automatic t_default();
        send_cell(40'h0, 1'b0, 53, 1'b0, -1, 8'h00);
        check_cell(8'h55, 53, 1'b0, "R5 R2 zero header default");
        send_cell(HA, 1'b1, 53, 1'b0, -1, 8'h00);
        check_cell(exp_hec(HA, 1, 1), 53, 1'b1, "R5 R4 idle default");
    endtask

    task automatic t_coset_off();
        wr_cfg(8'h22);
        send_cell(40'h0, 1'b0, 53, 1'b0, -1, 8'h00);
        check_cell(8'h00, 53, 1'b0, "R2 zero header no coset");
        send_cell(HB, 1'b0, 53, 1'b0, -1, 8'h00);
        check_cell(exp_hec(HB, 1, 0), 53, 1'b0, "R1 crc no coset");
    endtask

    task automatic t_valid_off();
        wr_cfg(8'h42);
        send_cell(HA, 1'b0, 53, 1'b0, -1, 8'h00);
        check_cell(HA[7:0], 53, 1'b0, "R3 assigned insert off");
        send_cell(HB, 1'b1, 53, 1'b0, -1, 8'h00);
        check_cell(exp_hec(HB, 1, 1), 53, 1'b1, "R4 idle insert on");
    endtask

    task automatic t_idle_off();
        wr_cfg(8'h60);
        send_cell(HB, 1'b1, 53, 1'b0, -1, 8'h00);
        check_cell(HB[7:0], 53, 1'b1, "R4 idle insert off");
        send_cell(HA, 1'b0, 53, 1'b0, -1, 8'h00);
        check_cell(exp_hec(HA, 1, 1), 53, 1'b0, "R3 assigned insert on");
    endtask

    task automatic t_mid_write();
        wr_cfg(8'h62);
        send_cell(HA, 1'b0, 53, 1'b0, 2, 8'h00);
        check_cell(exp_hec(HA, 1, 1), 53, 1'b0, "R7 write mid cell ignored");
        send_cell(HA, 1'b0, 53, 1'b0, -1, 8'h00);
        check_cell(HA[7:0], 53, 1'b0, "R7 write applies next cell");
        wr_cfg(8'h62);
    endtask

    task automatic t_gaps();
        send_cell(HB, 1'b0, 53, 1'b1, -1, 8'h00);
        check_cell(exp_hec(HB, 1, 1), 53, 1'b0, "R9 gapped cell");
    endtask

    task automatic t_restart();
        send_cell(HB, 1'b0, 20, 1'b0, -1, 8'h00);
        check_cell(exp_hec(HB, 1, 1), 20, 1'b0, "R8 truncated cell");
        send_cell(HA, 1'b0, 53, 1'b0, -1, 8'h00);
        check_cell(exp_hec(HA, 1, 1), 53, 1'b0, "R8 restart after truncation");
        // bytes after octet 53 without a start flag
        ocnt = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            sent[i] = 8'(8'hF0 + i);
            in_valid = 1'b1; in_soc = 1'b0; in_data = sent[i];
        end
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(ocnt == 6 && obuf[4] == sent[4], "R8 bytes outside cell unchanged", obuf[4], sent[4]);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_default();
        t_coset_off();
        t_valid_off();
        t_idle_off();
        t_mid_write();
        t_gaps();
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule